// File: doc/BRIEF.md
# Buffered Prescaled PWM Generator

This block produces one pulse-width-modulated output from a 15-bit counter that either climbs and wraps (edge-aligned operation) or climbs and then descends (center-aligned operation). The counter advances on a PWM clock tick. The tick is the bus clock divided by 1, 2, 4 or 8, as chosen by a 2-bit divider code.

Software presents the divider code, modulus, duty value and alignment choice on the input pins, then pulses `load_ok` for one clock. The block keeps a private active copy of every setting. It copies the pin values into that copy only at the first period boundary after the strobe, so a period never runs with a mix of old and new settings. The pending request clears once the copy is made. A one-clock `reload_pulse` marks the first bus clock of every period, and software can use it to time its next update.

Top module: `pwm_gen_top`

## Requirements
- R1: With `edge_align` = 1, the counter runs from 0 up to modulus-1 and wraps to 0. The period is divider x modulus bus clocks.
- R2: `presc_sel` codes 0, 1, 2 and 3 divide the bus clock by 1, 2, 4 and 8. Each counter value is held for that many bus clocks.
- R3: With `edge_align` = 0, the counter runs from 0 up to the modulus and back down to 0. The period is 2 x divider x modulus bus clocks.
- R4: The high time is divider x duty bus clocks in edge-aligned mode and 2 x divider x duty bus clocks in center-aligned mode. When duty is non-zero, the output is high in the first bus clock of every period.
- R5: New settings take effect only at the first period boundary after `load_ok` is sampled high. The period in progress keeps its old length and high time.
- R6: The pending load clears when the copy is made. Later changes on the setting inputs have no effect until `load_ok` is pulsed again.
- R7: A duty value of 0 holds `pwm_out` low for whole periods. A duty value at or above the modulus holds it high for whole periods.
- R8: `reload_pulse` is high for exactly one bus clock, in the first bus clock of every period. A modulus of 0 behaves as a modulus of 1.
- R9: After reset the active settings are: edge-aligned, divide by 1, modulus 1, duty 0. `pwm_out` is low, and the period is one bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 2 | Divider code for the PWM clock (buffered) |
| mod_in | input | 15 | Modulus value (buffered) |
| duty_in | input | 15 | Duty value (buffered) |
| edge_align | input | 1 | 1 selects edge-aligned operation, 0 selects center-aligned (buffered) |
| load_ok | input | 1 | One-clock strobe that requests a load at the next period boundary |
| pwm_out | output | 1 | PWM output |
| reload_pulse | output | 1 | High in the first bus clock of each period |

## Verification
A wrong counter value or direction shows on `pwm_out` within the same period, as a changed high time, because the output compares the counter against the duty value in every bus clock. A wrong divider phase or a missed wrap shows as a wrong spacing between two `reload_pulse` assertions, at the latest one period later. A fault in the load buffering shows in the first period after a boundary: a load that comes too early shortens or stretches the period already in progress, and a pending request that fails to clear lets later pin changes through without a strobe.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int unsigned CNT_W_DEF = 15;
  localparam int unsigned PSC_W_DEF = 2;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // Output level for a counter value. While climbing, the output is high below
  // the duty value. While descending, it is high at or below it, so that both
  // halves contribute the same number of high ticks.
  function automatic logic level_at(input int unsigned cval,
                                    input int unsigned dval,
                                    input logic        descending);
    if (descending) return (dval != 0) && (cval <= dval);
    return cval < dval;
  endfunction

  // Terminal count of the divider for a given code: 2**code - 1
  function automatic int unsigned div_limit(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned PSC_W   = PSC_W_DEF,
  parameter int unsigned RST_MOD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ok,
  input  logic             wrap,
  input  logic [PSC_W-1:0] presc_in,
  input  logic [CNT_W-1:0] mod_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             edge_in,
  output logic [PSC_W-1:0] act_presc,
  output logic [CNT_W-1:0] act_mod,
  output logic [CNT_W-1:0] act_duty,
  output logic             act_edge
);

  logic pending;
  logic take;

  // A load happens only at a period boundary, and only for a request that
  // was already pending before that boundary clock.
  assign take = wrap & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      act_presc <= '0;
      act_mod   <= CNT_W'(RST_MOD);
      act_duty  <= '0;
      act_edge  <= 1'b1;
    end else begin
      if (load_ok)   pending <= 1'b1;
      else if (take) pending <= 1'b0;
      if (take) begin
        act_presc <= presc_in;
        act_mod   <= mod_in;
        act_duty  <= duty_in;
        act_edge  <= edge_in;
      end
    end
  end

  AST_LOAD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(act_mod) && $stable(act_duty) && $stable(act_presc) && $stable(act_edge))); // R5

  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load_ok) |=> !pending); // R6

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_gen_pkg::*;
#(
  parameter int unsigned PSC_W = PSC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] presc,
  output logic             tick
);

  localparam int unsigned PC_W  = (1 << PSC_W) - 1;
  localparam int unsigned LIM_W = PC_W + 1;

  logic [PC_W-1:0]  pre_cnt;
  logic [LIM_W-1:0] lim;

  assign lim  = LIM_W'(div_limit(32'(presc)));
  assign tick = ({1'b0, pre_cnt} == lim);

  // The divider restarts on every tick. A divider change is applied only on
  // a tick (the period boundary), so the new ratio always starts from zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + PC_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pre_cnt} <= lim); // R2

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] mod_eff,
  input  logic             edge_mode,
  output logic [CNT_W-1:0] cnt,
  output dir_e             dir,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_nx;
  dir_e             dir_nx;
  logic             at_top;
  logic             at_end;

  assign at_top = (cnt == mod_eff - CNT_W'(1));

  always_comb begin
    cnt_nx = cnt + CNT_W'(1);
    dir_nx = DIR_UP;
    at_end = 1'b0;
    if (edge_mode) begin
      if (at_top) begin
        cnt_nx = '0;
        at_end = 1'b1;
      end
    end else if (dir == DIR_UP) begin
      if (at_top) dir_nx = DIR_DOWN;
    end else begin
      if (cnt <= CNT_W'(1)) begin
        cnt_nx = '0;
        at_end = 1'b1;
      end else begin
        cnt_nx = cnt - CNT_W'(1);
        dir_nx = DIR_DOWN;
      end
    end
  end

  assign wrap = tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (tick) begin
      cnt <= cnt_nx;
      dir <= dir_nx;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2

  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode |-> (cnt < mod_eff)); // R1

  AST_EDGE_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode |-> (dir == DIR_UP)); // R1

  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |-> (cnt <= mod_eff)); // R3

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] mod_eff,
  input  logic             wrap,
  output logic             pwm_out,
  output logic             reload_pulse
);

  assign pwm_out = level_at(32'(cnt), 32'(duty), dir == DIR_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_pulse <= 1'b0;
    else        reload_pulse <= wrap;
  end

  AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_out); // R7

  AST_DUTY_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (duty >= mod_eff) |-> pwm_out); // R7

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> (cnt == '0 && dir == DIR_UP)); // R8

endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned PSC_W = PSC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] presc_sel,
  input  logic [CNT_W-1:0] mod_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             edge_align,
  input  logic             load_ok,
  output logic             pwm_out,
  output logic             reload_pulse
);

  logic [PSC_W-1:0] act_presc;
  logic [CNT_W-1:0] act_mod;
  logic [CNT_W-1:0] act_duty;
  logic             act_edge;
  logic [CNT_W-1:0] mod_eff;
  logic [CNT_W-1:0] cnt;
  dir_e             dir;
  logic             tick;
  logic             wrap;

  // A modulus of zero runs as one
  assign mod_eff = (act_mod == '0) ? CNT_W'(1) : act_mod;

  pwm_shadow_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .RST_MOD(1)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (load_ok),
    .wrap      (wrap),
    .presc_in  (presc_sel),
    .mod_in    (mod_in),
    .duty_in   (duty_in),
    .edge_in   (edge_align),
    .act_presc (act_presc),
    .act_mod   (act_mod),
    .act_duty  (act_duty),
    .act_edge  (act_edge)
  );

  pwm_prescaler #(.PSC_W(PSC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .presc (act_presc),
    .tick  (tick)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mod_eff   (mod_eff),
    .edge_mode (act_edge),
    .cnt       (cnt),
    .dir       (dir),
    .wrap      (wrap)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt          (cnt),
    .dir          (dir),
    .duty         (act_duty),
    .mod_eff      (mod_eff),
    .wrap         (wrap),
    .pwm_out      (pwm_out),
    .reload_pulse (reload_pulse)
  );

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pwm_out); // R9

endmodule

// File: tb/tb_pwm_gen_top.sv
module tb_pwm_gen_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  presc_sel = '0;
  logic [14:0] mod_in = '0;
  logic [14:0] duty_in = '0;
  logic        edge_align = 1'b1;
  logic        load_ok = 1'b0;
  logic        pwm_out;
  logic        reload_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_gen_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .presc_sel    (presc_sel),
    .mod_in       (mod_in),
    .duty_in      (duty_in),
    .edge_align   (edge_align),
    .load_ok      (load_ok),
    .pwm_out      (pwm_out),
    .reload_pulse (reload_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Spec arithmetic restated: bus clocks per period and per high phase
  function automatic int exp_period(input int p, input int m, input bit e);
    int mm = (m == 0) ? 1 : m;
    return (1 << p) * mm * (e ? 1 : 2);
  endfunction

  function automatic int exp_high(input int p, input int m, input int d, input bit e);
    int mm = (m == 0) ? 1 : m;
    int dd = (d > mm) ? mm : d;
    return (1 << p) * dd * (e ? 1 : 2);
  endfunction

  task automatic sync_start();
    @(negedge clk);
    while (!reload_pulse) @(negedge clk);
  endtask

  task automatic apply_cfg(input int p, input int m, input int d, input bit e);
    @(negedge clk);
    presc_sel  = 2'(p);
    mod_in     = 15'(m);
    duty_in    = 15'(d);
    edge_align = e;
    load_ok    = 1'b1;
    @(negedge clk);
    load_ok = 1'b0;
    sync_start();
  endtask

  // Called at the first bus clock of a period; returns at the next one
  task automatic measure(output int per, output int hi, output int rpw, output int first_hi);
    per = 0; hi = 0; rpw = 0;
    first_hi = int'(pwm_out);
    do begin
      per++;
      hi  += int'(pwm_out);
      rpw += int'(reload_pulse);
      @(negedge clk);
    end while (!reload_pulse);
  endtask

  task automatic run_case(input string req, input int p, input int m, input int d, input bit e);
    int per, hi, rpw, fh;
    apply_cfg(p, m, d, e);
    measure(per, hi, rpw, fh);
    chk({req, " period"}, per, exp_period(p, m, e));
    chk({req, " high time"}, hi, exp_high(p, m, d, e));
    if (per > 1) chk("R8 reload pulse width", rpw, 1);
    if (d > 0)   chk("R4 high at period start", fh, 1);
  endtask

  task automatic t_reset();
    int per, hi, rpw, fh;
    @(negedge clk);
    chk("R9 output low after reset", int'(pwm_out), 0);
    sync_start();
    measure(per, hi, rpw, fh);
    chk("R9 reset period", per, 1);
    chk("R9 reset high time", hi, 0);
  endtask

  task automatic t_edge();
    run_case("R1", 0, 10, 3, 1'b1);
    run_case("R1", 0, 25, 12, 1'b1);
    run_case("R4", 0, 9, 1, 1'b1);
  endtask

  task automatic t_presc();
    run_case("R2", 1, 7, 5, 1'b1);
    run_case("R2", 2, 6, 1, 1'b1);
    run_case("R2", 3, 5, 2, 1'b1);
    run_case("R2", 1, 4, 3, 1'b0);
  endtask

  task automatic t_center();
    run_case("R3", 0, 8, 3, 1'b0);
    run_case("R3", 2, 5, 2, 1'b0);
    run_case("R3", 0, 1, 1, 1'b0);
    run_case("R4", 0, 12, 7, 1'b0);
  endtask

  task automatic t_limits();
    run_case("R7", 0, 10, 0, 1'b1);
    run_case("R7", 0, 10, 20, 1'b1);
    run_case("R7", 1, 6, 0, 1'b0);
    run_case("R7", 0, 6, 6, 1'b0);
  endtask

  task automatic t_mod_zero();
    run_case("R8", 0, 0, 1, 1'b1);
    run_case("R8", 1, 0, 0, 1'b0);
  endtask

  // A strobe in mid-period must not disturb the period in progress
  task automatic t_boundary();
    int n, per, hi, rpw, fh;
    apply_cfg(0, 40, 10, 1'b1);
    n = 0;
    repeat (10) begin
      n++;
      @(negedge clk);
    end
    presc_sel  = 2'd0;
    mod_in     = 15'd20;
    duty_in    = 15'd5;
    edge_align = 1'b1;
    load_ok    = 1'b1;
    n++;
    @(negedge clk);
    load_ok = 1'b0;
    while (!reload_pulse) begin
      n++;
      @(negedge clk);
    end
    chk("R5 old period kept after mid-period strobe", n, 40);
    measure(per, hi, rpw, fh);
    chk("R5 new period after boundary", per, 20);
    chk("R5 new high time after boundary", hi, 5);
  endtask

  // After the load the request is spent: pin changes alone do nothing
  task automatic t_ignore();
    int per, hi, rpw, fh;
    @(negedge clk);
    presc_sel  = 2'd2;
    mod_in     = 15'd13;
    duty_in    = 15'd2;
    edge_align = 1'b0;
    sync_start();
    for (int k = 0; k < 2; k++) begin
      measure(per, hi, rpw, fh);
      chk("R6 period unchanged without strobe", per, 20);
      chk("R6 high time unchanged without strobe", hi, 5);
    end
    run_case("R5", 2, 13, 2, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge();
    t_presc();
    t_center();
    t_limits();
    t_mod_zero();
    t_boundary();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule